// File: doc/BRIEF.md
# Flash Status Polling Generator

This block produces the byte a flash array returns on its low data lines while an embedded program or erase is running, suspended or has failed. The surrounding read path sends every read access through it: whenever the block raises `pass_array`, the read path must return ordinary array data. Otherwise the read returns the `status` byte. Controller events arrive as single-cycle pulses. These events are: start program, start erase, suspend request, suspend acknowledge, resume, done, fail, buffer abort and the read/reset clear.

Software polls the byte in two ways. Bit 7 is a data-polling bit: it shows the complement of the bit being programmed, and during an erase it shows 0. Bit 6 flips once per read access, not once per clock, so two reads in a row differ while work is still under way. Bit 5 flags an operation error and bit 1 flags an aborted buffered program. Either fault locks the block until a clear arrives. During an erase suspend the output depends on the address. A read inside a block that is being erased sees status. A read anywhere else, including a protected block, sees array data.

Top module: `flash_status_poll`

## Requirements
- R1: After reset, `pass_array`=1, `fault_lock`=0 and `status`=0x00. Whenever `pass_array`=1, `status` is 0x00.
- R2: During a program, bit 7 of `status` equals the inverse of the `prog_bit` captured when `start_prog` was accepted, and `pass_array`=0.
- R3: During an erase, bit 7 of `status` is 0 and `pass_array`=0.
- R4: Bit 6 is cleared to 0 when an operation starts. It inverts once per `read_stb` while a program or erase is active, and it never changes on a clock cycle with no read.
- R5: `op_done` during a program or an erase returns the block to read mode (`pass_array`=1).
- R6: During suspension, a read with `erase_hit`=0 gets `pass_array`=1. A read with `erase_hit`=1 gets status with bit 7 = 0.
- R7: After `susp_req`, bit 6 keeps inverting on reads with `erase_hit`=1 until `susp_ack`, and then it freezes. Reads with `erase_hit`=0 never advance it.
- R8: `resume_req` while suspended returns to the erase status, and toggling resumes.
- R9: `op_fail` sets bit 5 and `fault_lock`. Bit 7 keeps the value it had during the operation, and bit 6 keeps inverting on reads.
- R10: `buf_abort` during a program sets bit 1 with bit 5 = 0, and sets `fault_lock`.
- R11: While `fault_lock`=1, start requests are ignored. `clear_req` returns the block to read mode.
- R12: `status` bits 4, 3, 2 and 0 are always 0.
- R13: A start request that arrives while an operation is active or suspended is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_prog | input | 1 | Start program pulse (wins over start_erase) |
| start_erase | input | 1 | Start erase pulse |
| prog_bit | input | 1 | Data bit being programmed, captured at start |
| erase_hit | input | 1 | Current read address lies in a block being erased |
| read_stb | input | 1 | One pulse per read access |
| op_done | input | 1 | Operation completed successfully |
| op_fail | input | 1 | Operation error |
| buf_abort | input | 1 | Buffered program aborted |
| susp_req | input | 1 | Erase suspend requested |
| susp_ack | input | 1 | Controller has finished suspending |
| resume_req | input | 1 | Resume the suspended erase |
| clear_req | input | 1 | Read/reset command: clears a fault |
| status | output | 8 | Status byte |
| pass_array | output | 1 | Return array data instead of status |
| fault_lock | output | 1 | Fault held; commands blocked |

## Verification
A corrupted state register shows up on `pass_array` or `status` bit 7 in the cycle after the event that caused it. There is no extra latency, because the output is combinational from the state. A toggle flop that advances on the wrong condition is only visible at the next polled read. For this reason the stimulus places idle cycles, reads outside the erased block, and reads after the suspend acknowledge directly before reads that expose bit 6. A fault that fails to stick is exposed by a start request issued while the lock is held. A wrongly accepted request would change bit 7 or release the lock on the following cycle.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_PROG   = 3'd1,
      ST_ERASE  = 3'd2,
      ST_SUSPING = 3'd3,
      ST_SUSPD  = 3'd4,
      ST_FAULT  = 3'd5
   } poll_state_e;

   typedef struct packed {
      logic pbit;
      logic was_prog;
      logic err;
      logic abort;
   } poll_ctx_t;
endpackage

// File: rtl/poll_seq.sv
module poll_seq
   import flash_poll_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_prog,
   input  logic        start_erase,
   input  logic        prog_bit,
   input  logic        op_done,
   input  logic        op_fail,
   input  logic        buf_abort,
   input  logic        susp_req,
   input  logic        susp_ack,
   input  logic        resume_req,
   input  logic        clear_req,
   output poll_state_e st,
   output poll_ctx_t   ctx,
   output logic        start_acc
);
   poll_state_e st_d;
   poll_ctx_t   ctx_d;

   always_comb begin
      st_d      = st;
      ctx_d     = ctx;
      start_acc = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (start_prog) begin
               st_d      = ST_PROG;
               ctx_d     = '{pbit: prog_bit, was_prog: 1'b1, err: 1'b0, abort: 1'b0};
               start_acc = 1'b1;
            end else if (start_erase) begin
               st_d      = ST_ERASE;
               ctx_d     = '{pbit: 1'b0, was_prog: 1'b0, err: 1'b0, abort: 1'b0};
               start_acc = 1'b1;
            end
         end
         ST_PROG: begin
            if (op_fail) begin
               st_d      = ST_FAULT;
               ctx_d.err = 1'b1;
            end else if (buf_abort) begin
               st_d        = ST_FAULT;
               ctx_d.abort = 1'b1;
            end else if (op_done) begin
               st_d = ST_IDLE;
            end
         end
         ST_ERASE: begin
            if (op_fail) begin
               st_d      = ST_FAULT;
               ctx_d.err = 1'b1;
            end else if (op_done) begin
               st_d = ST_IDLE;
            end else if (susp_req) begin
               st_d = ST_SUSPING;
            end
         end
         ST_SUSPING: if (susp_ack)   st_d = ST_SUSPD;
         ST_SUSPD:   if (resume_req) st_d = ST_ERASE;
         ST_FAULT: begin
            if (clear_req) begin
               st_d        = ST_IDLE;
               ctx_d.err   = 1'b0;
               ctx_d.abort = 1'b0;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         ctx <= '0;
      end else begin
         st  <= st_d;
         ctx <= ctx_d;
      end
   end
endmodule

// File: rtl/poll_toggle.sv
module poll_toggle
   import flash_poll_pkg::*;
#(
   parameter bit FAULT_TOGGLE = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  poll_state_e st,
   input  logic        erase_hit,
   input  logic        read_stb,
   input  logic        clr,
   output logic        tog
);
   logic live;

   generate
      if (FAULT_TOGGLE) begin : g_fault_live
         always_comb live = (st == ST_PROG) || (st == ST_ERASE) || (st == ST_FAULT) ||
                            ((st == ST_SUSPING) && erase_hit);
      end else begin : g_fault_quiet
         always_comb live = (st == ST_PROG) || (st == ST_ERASE) ||
                            ((st == ST_SUSPING) && erase_hit);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tog <= 1'b0;
      else if (clr)              tog <= 1'b0;
      else if (read_stb && live) tog <= ~tog;
   end
endmodule

// File: rtl/poll_format.sv
module poll_format
   import flash_poll_pkg::*;
#(
   parameter int STATUS_W     = 8,
   parameter int POLL_BIT     = 7,
   parameter int TOGGLE_BIT   = 6,
   parameter int ERR_BIT      = 5,
   parameter int ABORT_BIT    = 1,
   parameter bit FAULT_TOGGLE = 1'b1
)(
   input  poll_state_e         st,
   input  poll_ctx_t           ctx,
   input  logic                erase_hit,
   input  logic                tog,
   output logic [STATUS_W-1:0] status,
   output logic                pass_array
);
   logic fault_tog;

   generate
      if (FAULT_TOGGLE) begin : g_ft
         always_comb fault_tog = tog;
      end else begin : g_fq
         always_comb fault_tog = 1'b0;
      end
   endgenerate

   always_comb begin
      status     = '0;
      pass_array = 1'b0;
      unique case (st)
         ST_IDLE: pass_array = 1'b1;
         ST_PROG: begin
            status[POLL_BIT]   = ~ctx.pbit;
            status[TOGGLE_BIT] = tog;
         end
         ST_ERASE: status[TOGGLE_BIT] = tog;
         ST_SUSPING, ST_SUSPD: begin
            if (erase_hit) status[TOGGLE_BIT] = tog;
            else           pass_array = 1'b1;
         end
         ST_FAULT: begin
            status[POLL_BIT]   = ctx.was_prog & ~ctx.pbit;
            status[TOGGLE_BIT] = fault_tog;
            status[ERR_BIT]    = ctx.err;
            status[ABORT_BIT]  = ctx.abort;
         end
         default: pass_array = 1'b1;
      endcase
   end
endmodule

// File: rtl/flash_status_poll.sv
module flash_status_poll
   import flash_poll_pkg::*;
#(
   parameter int STATUS_W     = 8,
   parameter int POLL_BIT     = 7,
   parameter int TOGGLE_BIT   = 6,
   parameter int ERR_BIT      = 5,
   parameter int ABORT_BIT    = 1,
   parameter bit FAULT_TOGGLE = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_prog,
   input  logic                start_erase,
   input  logic                prog_bit,
   input  logic                erase_hit,
   input  logic                read_stb,
   input  logic                op_done,
   input  logic                op_fail,
   input  logic                buf_abort,
   input  logic                susp_req,
   input  logic                susp_ack,
   input  logic                resume_req,
   input  logic                clear_req,
   output logic [STATUS_W-1:0] status,
   output logic                pass_array,
   output logic                fault_lock
);
   localparam int MAX_BIT = STATUS_W - 1;

   generate
      if (POLL_BIT > MAX_BIT || TOGGLE_BIT > MAX_BIT || ERR_BIT > MAX_BIT || ABORT_BIT > MAX_BIT)
         begin : g_bad_pos
         $error("status bit position outside status width");
      end
      if (POLL_BIT == TOGGLE_BIT || POLL_BIT == ERR_BIT || POLL_BIT == ABORT_BIT ||
          TOGGLE_BIT == ERR_BIT || TOGGLE_BIT == ABORT_BIT || ERR_BIT == ABORT_BIT)
         begin : g_bad_overlap
         $error("status bit positions must be distinct");
      end
   endgenerate

   poll_state_e st;
   poll_ctx_t   ctx;
   logic        start_acc;
   logic        tog;

   poll_seq u_seq (
      .clk(clk), .rst_n(rst_n),
      .start_prog(start_prog), .start_erase(start_erase), .prog_bit(prog_bit),
      .op_done(op_done), .op_fail(op_fail), .buf_abort(buf_abort),
      .susp_req(susp_req), .susp_ack(susp_ack), .resume_req(resume_req),
      .clear_req(clear_req),
      .st(st), .ctx(ctx), .start_acc(start_acc)
   );

   poll_toggle #(.FAULT_TOGGLE(FAULT_TOGGLE)) u_tog (
      .clk(clk), .rst_n(rst_n), .st(st), .erase_hit(erase_hit),
      .read_stb(read_stb), .clr(start_acc), .tog(tog)
   );

   poll_format #(
      .STATUS_W(STATUS_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT),
      .ERR_BIT(ERR_BIT), .ABORT_BIT(ABORT_BIT), .FAULT_TOGGLE(FAULT_TOGGLE)
   ) u_fmt (
      .st(st), .ctx(ctx), .erase_hit(erase_hit), .tog(tog),
      .status(status), .pass_array(pass_array)
   );

   assign fault_lock = (st == ST_FAULT);
endmodule

// File: rtl/flash_status_poll_chk.sv
module flash_status_poll_chk
   import flash_poll_pkg::*;
#(
   parameter int STATUS_W   = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6,
   parameter int ERR_BIT    = 5,
   parameter int ABORT_BIT  = 1
)(
   input logic                clk,
   input logic                rst_n,
   input logic                read_stb,
   input logic                start_prog,
   input logic                start_erase,
   input logic                clear_req,
   input logic [STATUS_W-1:0] status,
   input logic                pass_array,
   input logic                fault_lock,
   input poll_state_e         st,
   input logic                tog
);
   localparam logic [STATUS_W-1:0] USED =
      (STATUS_W'(1) << POLL_BIT) | (STATUS_W'(1) << TOGGLE_BIT) |
      (STATUS_W'(1) << ERR_BIT)  | (STATUS_W'(1) << ABORT_BIT);

   a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~USED) == '0);

   a_r1_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      pass_array |-> status == '0);

   a_r4_no_clock_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (!read_stb && !start_prog && !start_erase) |=> $stable(tog));

   a_r3_erase_dq7_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ERASE) |-> (!status[POLL_BIT] && !pass_array));

   a_r7_frozen_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SUSPD) |=> $stable(tog));

   a_r9_lock_hides_array: assert property (@(posedge clk) disable iff (!rst_n)
      fault_lock |-> !pass_array);

   a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_lock && !clear_req) |=> fault_lock);
endmodule

bind flash_status_poll flash_status_poll_chk #(
   .STATUS_W(STATUS_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT),
   .ERR_BIT(ERR_BIT), .ABORT_BIT(ABORT_BIT)
) u_chk (.*);

// File: tb/flash_status_poll_test.sv
`timescale 1ns/1ps
module flash_status_poll_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_prog = 0, start_erase = 0, prog_bit = 0, erase_hit = 0, read_stb = 0;
   logic op_done = 0, op_fail = 0, buf_abort = 0, susp_req = 0, susp_ack = 0;
   logic resume_req = 0, clear_req = 0;
   logic [7:0] status;
   logic pass_array, fault_lock;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   flash_status_poll uut (
      .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
      .prog_bit(prog_bit), .erase_hit(erase_hit), .read_stb(read_stb),
      .op_done(op_done), .op_fail(op_fail), .buf_abort(buf_abort),
      .susp_req(susp_req), .susp_ack(susp_ack), .resume_req(resume_req),
      .clear_req(clear_req), .status(status), .pass_array(pass_array),
      .fault_lock(fault_lock)
   );

   // inputs: sp se pb hit rd dn fl ab sq sk rs cl | status | pass lock
   localparam int NV = 33;
   localparam logic [21:0] VEC [NV] = '{
      {12'b1010_0000_0000, 8'h00, 2'b00}, // R2 program bit 1
      {12'b0000_1000_0000, 8'h40, 2'b00}, // R4 read flips
      {12'b0000_1000_0000, 8'h00, 2'b00}, // R4 read flips back
      {12'b0000_0000_0000, 8'h00, 2'b00}, // R4 no read, no flip
      {12'b0000_0100_0000, 8'h00, 2'b10}, // R5 done
      {12'b1000_0000_0000, 8'h80, 2'b00}, // R2 program bit 0
      {12'b0000_1000_0000, 8'hC0, 2'b00}, // R4
      {12'b0000_0001_0000, 8'hC2, 2'b01}, // R10 abort
      {12'b0000_1000_0000, 8'h82, 2'b01}, // R10 toggle in fault
      {12'b0100_0000_0000, 8'h82, 2'b01}, // R11 start ignored
      {12'b0000_0000_0001, 8'h00, 2'b10}, // R11 clear
      {12'b0101_0000_0000, 8'h00, 2'b00}, // R3 erase
      {12'b0001_1000_0000, 8'h40, 2'b00}, // R4
      {12'b1001_0000_0000, 8'h40, 2'b00}, // R13 start while busy
      {12'b0001_0000_1000, 8'h40, 2'b00}, // R7 suspend request
      {12'b0001_1000_0000, 8'h00, 2'b00}, // R7 toggle while suspending
      {12'b0000_1000_0000, 8'h00, 2'b10}, // R6 outside read
      {12'b0001_0000_0000, 8'h00, 2'b00}, // R7 outside read did not flip
      {12'b0001_1000_0000, 8'h40, 2'b00}, // R7
      {12'b0001_0000_0100, 8'h40, 2'b00}, // R7 suspend ack
      {12'b0001_1000_0000, 8'h40, 2'b00}, // R7 frozen
      {12'b0000_0000_0000, 8'h00, 2'b10}, // R6 outside
      {12'b0001_0000_0010, 8'h40, 2'b00}, // R8 resume
      {12'b0001_1000_0000, 8'h00, 2'b00}, // R8 toggling again
      {12'b0001_0010_0000, 8'h20, 2'b01}, // R9 erase fail
      {12'b0001_1000_0000, 8'h60, 2'b01}, // R9 toggle in fault
      {12'b1000_0000_0000, 8'h60, 2'b01}, // R11 start ignored
      {12'b0000_0000_0001, 8'h00, 2'b10}, // R11 clear
      {12'b1000_0000_0000, 8'h80, 2'b00}, // R2
      {12'b0000_0010_0000, 8'hA0, 2'b01}, // R9 program fail keeps DQ7
      {12'b0000_0000_0001, 8'h00, 2'b10}, // R11
      {12'b0101_0000_0000, 8'h00, 2'b00}, // R3
      {12'b0001_0100_0000, 8'h00, 2'b10}  // R5 erase done
   };
   localparam int REQ [NV] = '{2,4,4,4,5,2,4,10,10,11,11,3,4,13,7,7,6,7,7,7,7,6,8,8,9,9,11,11,2,9,11,3,5};

   task automatic check(input bit ok, input int req, input string what,
                        input logic [9:0] act, input logic [9:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [11:0] v);
      @(negedge clk);
      {start_prog, start_erase, prog_bit, erase_hit, read_stb, op_done,
       op_fail, buf_abort, susp_req, susp_ack, resume_req, clear_req} = v;
      @(negedge clk);
      {start_prog, start_erase, read_stb, op_done, op_fail, buf_abort,
       susp_req, susp_ack, resume_req, clear_req} = '0;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(status == 8'h00 && pass_array && !fault_lock, 1, "reset state",
            {status, pass_array, fault_lock}, 10'b0000_0000_10);
      rst_n = 1'b1;
      @(negedge clk);
      check(status == 8'h00 && pass_array && !fault_lock, 1, "after reset release",
            {status, pass_array, fault_lock}, 10'b0000_0000_10);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][21:10]);
         check({status, pass_array, fault_lock} == VEC[i][9:0], REQ[i],
               $sformatf("vector %0d", i), {status, pass_array, fault_lock}, VEC[i][9:0]);
      end

      // R12 reserved bits stay low during a toggling fault
      apply(12'b1000_0000_0000);
      apply(12'b0000_0001_0000);
      apply(12'b0000_1000_0000);
      check((status & 8'b0001_1101) == 8'h00, 12, "reserved bits",
            {status, 2'b00}, {8'h00, 2'b00});

      // R1 reset in the middle of a locked fault
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(status == 8'h00 && pass_array && !fault_lock, 1, "reset mid fault",
            {status, pass_array, fault_lock}, 10'b0000_0000_10);

      // R4 first read after new start shows cleared toggle
      erase_hit = 1'b0;
      apply(12'b0100_0000_0000);
      check(status == 8'h00 && !pass_array, 4, "toggle cleared at start",
            {status, pass_array, fault_lock}, 10'b0000_0000_00);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule